// File: doc/BRIEF.md
# Addressed SPI Slave Front End with Hold Pause

This block is the serial front end of a peripheral that shares an SPI bus with up to three other devices of the same kind. It oversamples chip select, serial clock, serial data in and a hold input with the system clock. It assembles bytes MSB first on rising serial-clock edges and shifts read data out MSB first on falling edges. It also drives a tri-state enable for the serial output pin.

Every frame opens with an address byte. Its upper six bits must equal a device-type parameter and its lower two bits must equal a pair of strap pins. Only then does the block take part in the frame. Each complete byte after a matching address is handed to a register core as a one-cycle strobe with the byte value. At the end of every accepted byte the block captures the core's parallel read value, and that value goes out during the next byte. A hold input pauses the serial sequence mid-byte without losing its place. After reset the block stays deaf until chip select has fallen once.

Top module: `spi_addr_hold_slave`

## Requirements
- R1: Serial input is sampled on each rising serial-clock edge and bytes are assembled MSB first.
- R2: Serial output changes only on falling serial-clock edges, MSB first. The byte sent during data byte k is the value on `rd_byte` when byte k-1 completed (the address byte counts as byte 0).
- R3: While chip select is high, `sdo_oe` is 0 and the bit position, address state and pending byte are cleared.
- R4: After reset, no byte is accepted and `sdo_oe` stays 0 until chip select makes a high-to-low transition.
- R5: The first byte of a frame is accepted as an address only if bits [7:2] equal `DEV_TYPE` and bits [1:0] equal `strap[1:0]`. Otherwise the frame gives no strobes and `sdo_oe` stays 0.
- R6: Taking `hold_n` low while the serial clock is low pauses the frame. Clock edges are then ignored, the bit position and partial byte are kept, and `sdo_oe` is 0.
- R7: Returning `hold_n` high while the serial clock is low resumes the byte at the bit where it stopped, and `sdo_oe` returns.
- R8: Each complete byte after a matching address gives exactly one single-cycle `wr_valid` pulse, with the byte on `wr_byte`.
- R9: A chip-select rising edge in the middle of a byte discards the partial byte. The next frame starts again with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| strap | input | 2 | Board strap giving the low two address bits |
| rd_byte | input | 8 | Parallel read value captured at each byte end |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Tri-state enable for the serial output pin |
| wr_valid | output | 1 | One-cycle strobe for a received byte |
| wr_byte | output | 8 | Received byte, valid with `wr_valid` |

## Verification
Data bytes 0x81, 0x7E, 0x00, 0xFF and 0x96 are used. Asymmetric bit patterns expose bit-order or off-by-one framing errors, and the all-zero and all-one bytes expose a stuck serial path. The address is tried as an exact match, with only the strap bits wrong, and with only the type bits wrong, so the two halves of the compare are tested separately. Frames sent before chip select has ever fallen, frames cut off after four bits, and a hold with extra clock toggles in the middle of a byte show whether the block is gated, cleared and frozen at the right moments. The bench checks read data shifted back on every accepted data byte.

// File: rtl/spi_addr_hold_pkg.sv
package spi_addr_hold_pkg;

  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 2;
  localparam int TYPE_W  = BYTE_W - STRAP_W;
  localparam int CNT_W   = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // raw pin levels, as seen at the package boundary
  typedef struct packed {
    logic csn;
    logic sck;
    logic sdi;
    logic holdn;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);

  // csn resets low so a pin that is already low at reset gives no falling edge
  localparam pins_t PINS_RST = '{csn: 1'b0, sck: 1'b0, sdi: 1'b0, holdn: 1'b1};

endpackage

// File: rtl/sah_pin_sync.sv
module sah_pin_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sah_framer.sv
module sah_framer
  import spi_addr_hold_pkg::*;
#(
  parameter logic [TYPE_W-1:0] DEV_TYPE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pins_t              pin_s,
  input  logic [STRAP_W-1:0] strap,
  output logic               sel,
  output logic               matched,
  output logic               hold_act,
  output logic [CNT_W-1:0]   bit_pos,
  output logic               tx_load,
  output logic               tx_shift,
  output logic               wr_valid,
  output byte_t              wr_byte
);

  logic             csn_q, sck_q;
  logic             sel_q, sel_d;
  logic             first_q, first_d;
  logic             match_q, match_d;
  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  byte_t            sh_q, sh_d;
  logic             wv_q, wv_d;
  byte_t            wb_q, wb_d;

  logic  sck_rise, sck_fall, cs_fall, shift_en, byte_done, addr_ok;
  byte_t byte_val;

  always_comb begin
    sck_rise  = pin_s.sck & ~sck_q;
    sck_fall  = ~pin_s.sck & sck_q;
    cs_fall   = ~pin_s.csn & csn_q;
    shift_en  = sel_q & ~pin_s.csn & ~hold_q & sck_rise;
    byte_val  = {sh_q[BYTE_W-2:0], pin_s.sdi};
    byte_done = shift_en && (cnt_q == CNT_W'(BYTE_W-1));
    addr_ok   = (byte_val[BYTE_W-1:STRAP_W] == DEV_TYPE) &&
                (byte_val[STRAP_W-1:0] == strap);
    tx_load   = byte_done && (first_q ? addr_ok : match_q);
    tx_shift  = match_q & ~pin_s.csn & ~hold_q & sck_fall;
  end

  always_comb begin
    sel_d   = sel_q;
    first_d = first_q;
    match_d = match_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    wv_d    = 1'b0;
    wb_d    = wb_q;
    // pause state only moves while the serial clock is low
    hold_d  = pin_s.sck ? hold_q : ~pin_s.holdn;
    if (pin_s.csn) begin
      sel_d   = 1'b0;
      first_d = 1'b1;
      match_d = 1'b0;
      cnt_d   = '0;
    end else begin
      if (cs_fall) sel_d = 1'b1;
      if (shift_en) begin
        sh_d  = byte_val;
        cnt_d = byte_done ? '0 : cnt_q + 1'b1;
        if (byte_done) begin
          first_d = 1'b0;
          if (first_q) begin
            match_d = addr_ok;
          end else if (match_q) begin
            wv_d = 1'b1;
            wb_d = byte_val;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q   <= PINS_RST.csn;
      sck_q   <= PINS_RST.sck;
      sel_q   <= 1'b0;
      first_q <= 1'b1;
      match_q <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      wv_q    <= 1'b0;
      wb_q    <= '0;
    end else begin
      csn_q   <= pin_s.csn;
      sck_q   <= pin_s.sck;
      sel_q   <= sel_d;
      first_q <= first_d;
      match_q <= match_d;
      hold_q  <= hold_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      wv_q    <= wv_d;
      wb_q    <= wb_d;
    end
  end

  assign sel      = sel_q;
  assign matched  = match_q;
  assign hold_act = hold_q;
  assign bit_pos  = cnt_q;
  assign wr_valid = wv_q;
  assign wr_byte  = wb_q;

endmodule

// File: rtl/sah_txpath.sv
module sah_txpath
  import spi_addr_hold_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  shift,
  input  byte_t rd_byte,
  input  logic  matched,
  input  logic  hold_act,
  input  logic  csn_s,
  output logic  sdo,
  output logic  sdo_oe
);

  byte_t tx_q, tx_d;
  logic  bit_q, bit_d;

  always_comb begin
    tx_d  = tx_q;
    bit_d = bit_q;
    if (load) begin
      tx_d = rd_byte;
    end else if (shift) begin
      bit_d = tx_q[BYTE_W-1];
      tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      bit_q <= bit_d;
    end
  end

  assign sdo_oe = matched & ~hold_act & ~csn_s;
  assign sdo    = bit_q & sdo_oe;

endmodule

// File: rtl/spi_addr_hold_slave.sv
module spi_addr_hold_slave
  import spi_addr_hold_pkg::*;
#(
  parameter logic [5:0] DEV_TYPE    = 6'b101001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic       hold_n,
  input  logic [1:0] strap,
  input  logic [7:0] rd_byte,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       wr_valid,
  output logic [7:0] wr_byte
);

  pins_t            pin_raw, pin_s;
  logic [PINS_W-1:0] pin_s_bits;
  logic             sel_w, matched_w, hold_w, load_w, shift_w;
  logic [CNT_W-1:0] bit_pos_w;

  assign pin_raw = '{csn: cs_n, sck: sck, sdi: sdi, holdn: hold_n};

  sah_pin_sync #(
    .W       (PINS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_s_bits)
  );

  assign pin_s = pin_s_bits;

  sah_framer #(
    .DEV_TYPE (DEV_TYPE)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .strap    (strap),
    .sel      (sel_w),
    .matched  (matched_w),
    .hold_act (hold_w),
    .bit_pos  (bit_pos_w),
    .tx_load  (load_w),
    .tx_shift (shift_w),
    .wr_valid (wr_valid),
    .wr_byte  (wr_byte)
  );

  sah_txpath u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .shift    (shift_w),
    .rd_byte  (rd_byte),
    .matched  (matched_w),
    .hold_act (hold_w),
    .csn_s    (pin_s.csn),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

endmodule

// File: rtl/spi_addr_hold_slave_chk.sv
module spi_addr_hold_slave_chk
  import spi_addr_hold_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             csn_s,
  input logic             sel,
  input logic             matched,
  input logic             hold_act,
  input logic [CNT_W-1:0] bit_pos,
  input logic             sdo_oe,
  input logic             wr_valid
);

  // R3
  idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !sdo_oe);

  // R6
  hold_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !sdo_oe);

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !csn_s) |=> $stable(bit_pos));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R5
  strobe_matched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> matched);

  // R4
  strobe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sel);

endmodule

bind spi_addr_hold_slave spi_addr_hold_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn_s    (pin_s.csn),
  .sel      (sel_w),
  .matched  (matched_w),
  .hold_act (hold_w),
  .bit_pos  (bit_pos_w),
  .sdo_oe   (sdo_oe),
  .wr_valid (wr_valid)
);

// File: tb/spi_addr_hold_slave_tb_top.sv
module spi_addr_hold_slave_tb_top;

  localparam logic [5:0] TYPE  = 6'b101001;
  localparam logic [1:0] STRP  = 2'b10;
  localparam logic [7:0] ADDR  = {TYPE, STRP};
  localparam int         HALF  = 8;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, sdi, hold_n;
  logic [1:0] strap;
  logic [7:0] rd_byte;
  logic       sdo, sdo_oe, wr_valid;
  logic [7:0] wr_byte;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  spi_addr_hold_slave #(.DEV_TYPE(TYPE), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .hold_n(hold_n), .strap(strap), .rd_byte(rd_byte), .sdo(sdo),
    .sdo_oe(sdo_oe), .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every strobe must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected strobe", wr_byte, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(wr_byte == e, "R1 R8", "received byte", wr_byte, e);
      end
    end
  end

  task automatic frame_open();
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic frame_close();
    wclk(HALF);
    cs_n = 1'b1;
    wclk(2 * HALF);
  endtask

  // one byte; optional pause before bit index hold_at (7..0), -1 for none
  task automatic xfer(input logic [7:0] mosi, input logic [7:0] next_rd,
                      input bit chk_miso, input logic [7:0] exp_miso,
                      input int hold_at);
    logic [7:0] got;
    got = '0;
    rd_byte = next_rd;
    for (int i = 7; i >= 0; i--) begin
      sdi = mosi[i];
      if (i == hold_at) begin
        hold_n = 1'b0;
        wclk(HALF);
        check(sdo_oe == 1'b0, "R6", "oe during pause", {7'd0, sdo_oe}, 8'h00);
        for (int k = 0; k < 3; k++) begin
          sdi = ~sdi;
          sck = 1'b1; wclk(HALF);
          sck = 1'b0; wclk(HALF);
        end
        hold_n = 1'b1;
        sdi = mosi[i];
        wclk(HALF);
        check(sdo_oe == 1'b1, "R7", "oe after resume", {7'd0, sdo_oe}, 8'h01);
      end
      wclk(HALF);
      got[i] = sdo;
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
    if (chk_miso) check(got == exp_miso, "R2", "shifted-out byte", got, exp_miso);
  endtask

  task automatic partial(input logic [7:0] mosi, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = mosi[i];
      wclk(HALF);
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; sdi = 1'b0; hold_n = 1'b1;
    strap = STRP; rd_byte = 8'h00;
    wclk(5);
    rst_n = 1'b1;
    wclk(4);
    // R3 reset state
    check(sdo_oe == 1'b0, "R3", "oe after reset", {7'd0, sdo_oe}, 8'h00);
    check(wr_valid == 1'b0, "R3", "strobe after reset", {7'd0, wr_valid}, 8'h00);

    // R4: chip select was low through reset, never fell: frame ignored
    xfer(ADDR, 8'h11, 1'b0, 8'h00, -1);
    check(sdo_oe == 1'b0, "R4", "oe before first fall", {7'd0, sdo_oe}, 8'h00);
    xfer(8'h3C, 8'h22, 1'b0, 8'h00, -1);
    wclk(HALF);
    check(exp_q.size() == 0, "R4", "no strobe before arming", 8'(exp_q.size()), 8'h00);
    cs_n = 1'b1;
    wclk(2 * HALF);

    // R1 R2 R8: matching frame with two data bytes
    frame_open();
    xfer(ADDR, 8'h5A, 1'b0, 8'h00, -1);
    check(sdo_oe == 1'b1, "R5", "oe after address match", {7'd0, sdo_oe}, 8'h01);
    exp_q.push_back(8'h81);
    xfer(8'h81, 8'hC3, 1'b1, 8'h5A, -1);
    exp_q.push_back(8'h7E);
    xfer(8'h7E, 8'h00, 1'b1, 8'hC3, -1);
    frame_close();
    check(sdo_oe == 1'b0, "R3", "oe after deselect", {7'd0, sdo_oe}, 8'h00);

    // R5: strap bits wrong
    frame_open();
    xfer({TYPE, ~STRP}, 8'h44, 1'b0, 8'h00, -1);
    check(sdo_oe == 1'b0, "R5", "oe on strap mismatch", {7'd0, sdo_oe}, 8'h00);
    xfer(8'h11, 8'h00, 1'b0, 8'h00, -1);
    frame_close();

    // R5: type bits wrong
    frame_open();
    xfer({TYPE ^ 6'b000001, STRP}, 8'h44, 1'b0, 8'h00, -1);
    check(sdo_oe == 1'b0, "R5", "oe on type mismatch", {7'd0, sdo_oe}, 8'h00);
    xfer(8'h12, 8'h00, 1'b0, 8'h00, -1);
    frame_close();

    // R6 R7: pause in the middle of a byte with clock toggles
    frame_open();
    xfer(ADDR, 8'hA5, 1'b0, 8'h00, -1);
    exp_q.push_back(8'h96);
    xfer(8'h96, 8'hFF, 1'b1, 8'hA5, 3);
    exp_q.push_back(8'h00);
    xfer(8'h00, 8'h0F, 1'b1, 8'hFF, -1);
    exp_q.push_back(8'hFF);
    xfer(8'hFF, 8'h00, 1'b1, 8'h0F, -1);
    frame_close();

    // R9: frame cut mid-byte, then a fresh frame must still address
    frame_open();
    xfer(ADDR, 8'h00, 1'b0, 8'h00, -1);
    partial(8'hF0, 4);
    frame_close();
    frame_open();
    xfer(ADDR, 8'h3B, 1'b0, 8'h00, -1);
    exp_q.push_back(8'hE7);
    xfer(8'hE7, 8'h00, 1'b1, 8'h3B, -1);
    frame_close();

    wclk(HALF);
    check(exp_q.size() == 0, "R8 R9", "all expected strobes seen", 8'(exp_q.size()), 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule